// File: doc/BRIEF.md
# Load-Store Dependence Predictor

This block decides whether a load may go ahead of older stores whose addresses are still unknown. A table of saturating confidence counters is indexed by the low bits of the load's instruction address. It learns from each load's own history and never looks at store addresses when it predicts. A load with full confidence is marked speculative and may read the data cache at once. Any other load is told to wait until every older store address is known, which is the safe fallback.

Every speculative load that is accepted is placed in a small tracking buffer along with its age tag and data address. When an older store resolves its address, the block compares that address against the tracked younger loads. A match means the prediction was wrong. The block then raises a violation naming the oldest offending load, so that load and its dependents can be re-executed. It also resets that load's confidence and drops every tracked load at or after the offending one. A load that completes cleanly raises its counter by one and frees its tracking slot.

The lookup port is valid/ready. A lookup transfers on a cycle where `lk_valid` and `lk_ready` are both high. `lk_spec` is a same-cycle answer and is meaningful while `lk_valid` is high. The requester may hold `lk_valid` and its payload steady while `lk_ready` is low. `lk_ready` drops only when the tracking buffer is full, and a lookup that is not accepted changes no state. The completion and store-resolution strobes are plain pins and are taken on every cycle they are high.

Top module: `ldst_dep_pred`

## Requirements
- R1: After reset every confidence counter is 0, the tracking buffer is empty, `lk_ready` is 1, `viol` is 0, and every lookup answers wait (`lk_spec` = 0).
- R2: A lookup answers speculate (`lk_spec` = 1) exactly when the 4-bit counter selected by `lk_pc[5:0]` equals 15. Otherwise it answers wait.
- R3: Each cycle with `cm_valid` high raises the counter selected by `cm_pc[5:0]` by one. The counter stays at 15 once it is there.
- R4: An accepted lookup that answers speculate takes a tracking slot holding its age tag, address and table index. A lookup that answers wait takes no slot and can never be flagged.
- R5: A resolving store is compared only against tracked loads whose age tag is strictly larger than its own. A larger tag means younger, and tags do not wrap while loads are in flight.
- R6: A store matches a load when their addresses agree in every bit above bit 2, that is, when both fall in the same aligned 8-byte block.
- R7: A store with at least one match drives `viol` high for exactly the next cycle. `viol_age` then carries the smallest age tag among the matching loads, whatever slots they occupy.
- R8: On a violation, the counter of the reported load's index is set to 0 and every tracked load whose age tag is greater than or equal to the reported tag is dropped.
- R9: A completion whose `cm_age` equals a tracked load's tag frees that slot, and later stores are no longer compared against it.
- R10: With all 8 slots taken, `lk_ready` is 0 and an offered lookup is not accepted and leaves no slot behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted (a tracking slot is free) |
| lk_pc | input | 32 | Instruction address of the load being looked up |
| lk_age | input | 8 | Age tag of the load (larger is younger) |
| lk_addr | input | 32 | Data address of the load |
| lk_spec | output | 1 | 1 = speculate now, 0 = wait for older store addresses |
| cm_valid | input | 1 | A load completed without conflict |
| cm_pc | input | 32 | Instruction address of the completing load |
| cm_age | input | 8 | Age tag of the completing load |
| st_valid | input | 1 | An older store has resolved its address |
| st_age | input | 8 | Age tag of the resolving store |
| st_addr | input | 32 | Resolved store address |
| viol | output | 1 | One-cycle request to re-execute a load and its dependents |
| viol_age | output | 8 | Age tag of the oldest conflicting load |

## Verification
The store check is tried against a series of address patterns. These include an address shared with a load that only waited, an address held by an older load, addresses in a neighbouring 8-byte block, and a different byte in the same block. Each of these checks one step of the match on its own: tracking, age order, or granularity. Two younger loads matching one store are tried in both allocation orders, which shows the oldest is picked by age and not by slot position. Counter training is probed at 14 and 15 completions and past saturation. Filling all slots, then releasing one and flushing the rest, separates back-pressure, release and flush.

// File: rtl/ldp_pkg.sv
package ldp_pkg;
  localparam int unsigned LDP_PC_W   = 32;
  localparam int unsigned LDP_ADDR_W = 32;
  localparam int unsigned LDP_AGE_W  = 8;
  localparam int unsigned LDP_IDX_W  = 6;
  localparam int unsigned LDP_CNT_W  = 4;
  localparam int unsigned LDP_SLOTS  = 8;
  localparam int unsigned LDP_GRAN   = 3;
endpackage

// File: rtl/ldp_conf_table.sv
module ldp_conf_table #(
  parameter int unsigned IDX_W = ldp_pkg::LDP_IDX_W,
  parameter int unsigned CNT_W = ldp_pkg::LDP_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_sat,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) cnt[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (clr_en && clr_idx == IDX_W'(e))
          cnt[e] <= '0;
        else if (inc_en && inc_idx == IDX_W'(e) && cnt[e] != CMAX)
          cnt[e] <= cnt[e] + 1'b1;
      end
    end
  end

  assign rd_sat = (cnt[rd_idx] == CMAX);

  // R3
  conf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !(clr_en && clr_idx == inc_idx) && cnt[inc_idx] != CMAX)
    |=> cnt[$past(inc_idx)] == $past(cnt[inc_idx]) + 1'b1);

  // R8
  conf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> cnt[$past(clr_idx)] == '0);
endmodule

// File: rtl/ldp_oldest_pick.sv
module ldp_oldest_pick #(
  parameter int unsigned N     = ldp_pkg::LDP_SLOTS,
  parameter int unsigned AGE_W = ldp_pkg::LDP_AGE_W,
  localparam int unsigned SW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            hit,
  input  logic [N-1:0][AGE_W-1:0] age,
  output logic                    any,
  output logic [AGE_W-1:0]        best_age,
  output logic [SW-1:0]           best_slot
);
  always_comb begin
    any       = 1'b0;
    best_age  = '0;
    best_slot = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i] && (!any || age[i] < best_age)) begin
        any       = 1'b1;
        best_age  = age[i];
        best_slot = SW'(i);
      end
    end
  end
endmodule

// File: rtl/ldp_tracker.sv
module ldp_tracker #(
  parameter int unsigned SLOTS = ldp_pkg::LDP_SLOTS,
  parameter int unsigned AGE_W = ldp_pkg::LDP_AGE_W,
  parameter int unsigned BLK_W = ldp_pkg::LDP_ADDR_W - ldp_pkg::LDP_GRAN,
  parameter int unsigned IDX_W = ldp_pkg::LDP_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [AGE_W-1:0] alloc_age,
  input  logic [BLK_W-1:0] alloc_blk,
  input  logic [IDX_W-1:0] alloc_idx,
  output logic             full,
  input  logic             rel_en,
  input  logic [AGE_W-1:0] rel_age,
  input  logic             st_en,
  input  logic [AGE_W-1:0] st_age,
  input  logic [BLK_W-1:0] st_blk,
  output logic             hit_any,
  output logic [AGE_W-1:0] hit_age,
  output logic [IDX_W-1:0] hit_idx
);
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0]            slot_v;
  logic [SLOTS-1:0][AGE_W-1:0] slot_age;
  logic [SLOTS-1:0][BLK_W-1:0] slot_blk;
  logic [SLOTS-1:0][IDX_W-1:0] slot_idx;
  logic [SLOTS-1:0]            grant;
  logic [SLOTS-1:0]            hit;
  logic [SW-1:0]               hit_slot;

  // lowest free slot
  always_comb begin
    grant = '0;
    for (int i = 0; i < SLOTS; i++)
      if (!slot_v[i] && grant == '0) grant[i] = 1'b1;
  end

  assign full = &slot_v;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      assign hit[i] = st_en && slot_v[i] && (slot_age[i] > st_age) &&
                      (slot_blk[i] == st_blk);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_v[i]   <= 1'b0;
          slot_age[i] <= '0;
          slot_blk[i] <= '0;
          slot_idx[i] <= '0;
        end else if (alloc_en && grant[i]) begin
          slot_v[i]   <= 1'b1;
          slot_age[i] <= alloc_age;
          slot_blk[i] <= alloc_blk;
          slot_idx[i] <= alloc_idx;
        end else if (hit_any && slot_v[i] && slot_age[i] >= hit_age) begin
          slot_v[i] <= 1'b0;
        end else if (rel_en && slot_v[i] && slot_age[i] == rel_age) begin
          slot_v[i] <= 1'b0;
        end
      end

      // R8
      flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_any && slot_v[i] && slot_age[i] >= hit_age) |=> !slot_v[i]);
    end
  endgenerate

  ldp_oldest_pick #(.N(SLOTS), .AGE_W(AGE_W)) u_pick (
    .hit      (hit),
    .age      (slot_age),
    .any      (hit_any),
    .best_age (hit_age),
    .best_slot(hit_slot)
  );

  assign hit_idx = slot_idx[hit_slot];

  // R10
  no_alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);

  // R4
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/ldst_dep_pred.sv
module ldst_dep_pred #(
  parameter int unsigned PC_W   = ldp_pkg::LDP_PC_W,
  parameter int unsigned ADDR_W = ldp_pkg::LDP_ADDR_W,
  parameter int unsigned AGE_W  = ldp_pkg::LDP_AGE_W,
  parameter int unsigned IDX_W  = ldp_pkg::LDP_IDX_W,
  parameter int unsigned CNT_W  = ldp_pkg::LDP_CNT_W,
  parameter int unsigned SLOTS  = ldp_pkg::LDP_SLOTS,
  parameter int unsigned GRAN   = ldp_pkg::LDP_GRAN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [AGE_W-1:0]  lk_age,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_spec,
  input  logic              cm_valid,
  input  logic [PC_W-1:0]   cm_pc,
  input  logic [AGE_W-1:0]  cm_age,
  input  logic              st_valid,
  input  logic [AGE_W-1:0]  st_age,
  input  logic [ADDR_W-1:0] st_addr,
  output logic              viol,
  output logic [AGE_W-1:0]  viol_age
);
  localparam int unsigned BLK_W = ADDR_W - GRAN;

  logic             full;
  logic             alloc_en;
  logic             hit_any;
  logic [AGE_W-1:0] hit_age;
  logic [IDX_W-1:0] hit_idx;
  logic             unused_bits;

  assign unused_bits = ^{lk_pc[PC_W-1:IDX_W], cm_pc[PC_W-1:IDX_W],
                         lk_addr[GRAN-1:0], st_addr[GRAN-1:0]};

  assign lk_ready = !full;
  assign alloc_en = lk_valid && lk_ready && lk_spec;

  ldp_conf_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lk_pc[IDX_W-1:0]),
    .rd_sat (lk_spec),
    .inc_en (cm_valid),
    .inc_idx(cm_pc[IDX_W-1:0]),
    .clr_en (hit_any),
    .clr_idx(hit_idx)
  );

  ldp_tracker #(.SLOTS(SLOTS), .AGE_W(AGE_W), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (alloc_en),
    .alloc_age(lk_age),
    .alloc_blk(lk_addr[ADDR_W-1:GRAN]),
    .alloc_idx(lk_pc[IDX_W-1:0]),
    .full     (full),
    .rel_en   (cm_valid),
    .rel_age  (cm_age),
    .st_en    (st_valid),
    .st_age   (st_age),
    .st_blk   (st_addr[ADDR_W-1:GRAN]),
    .hit_any  (hit_any),
    .hit_age  (hit_age),
    .hit_idx  (hit_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol     <= 1'b0;
      viol_age <= '0;
    end else begin
      viol     <= hit_any;
      viol_age <= hit_any ? hit_age : '0;
    end
  end

  // R7
  viol_from_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(st_valid));

  // R7
  viol_older_than_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> viol_age > $past(st_age));
endmodule

// File: tb/tb_ldst_dep_pred.sv
`timescale 1ns/1ps
module tb_ldst_dep_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_pc = '0;
  logic [7:0]  lk_age = '0;
  logic [31:0] lk_addr = '0;
  logic        lk_spec;
  logic        cm_valid = 1'b0;
  logic [31:0] cm_pc = '0;
  logic [7:0]  cm_age = '0;
  logic        st_valid = 1'b0;
  logic [7:0]  st_age = '0;
  logic [31:0] st_addr = '0;
  logic        viol;
  logic [7:0]  viol_age;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ldst_dep_pred dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc), .lk_age(lk_age),
    .lk_addr(lk_addr), .lk_spec(lk_spec),
    .cm_valid(cm_valid), .cm_pc(cm_pc), .cm_age(cm_age),
    .st_valid(st_valid), .st_age(st_age), .st_addr(st_addr),
    .viol(viol), .viol_age(viol_age)
  );

  // vector: op[42:41] pc[40:33] age[32:25] addr[24:9] exp[8] eage[7:0]
  localparam logic [1:0] OP_LK = 2'd0, OP_CM = 2'd1, OP_ST = 2'd2;
  localparam int NV = 18;
  localparam logic [42:0] VEC [NV] = '{
    {OP_LK, 8'h05, 8'd10, 16'h0100, 1'b1, 8'd0},  // R2 R4 saturated pc speculates
    {OP_LK, 8'h09, 8'd20, 16'h0200, 1'b1, 8'd0},  // R2
    {OP_LK, 8'h11, 8'd30, 16'h0300, 1'b0, 8'd0},  // R2 untrained pc waits
    {OP_ST, 8'h00, 8'd5,  16'h0300, 1'b0, 8'd0},  // R4 waiting load never tracked
    {OP_ST, 8'h00, 8'd25, 16'h0100, 1'b0, 8'd0},  // R5 load older than store
    {OP_ST, 8'h00, 8'd5,  16'h0108, 1'b0, 8'd0},  // R6 next 8-byte block
    {OP_ST, 8'h00, 8'd5,  16'h0107, 1'b1, 8'd10}, // R6 R7 same block, other byte
    {OP_ST, 8'h00, 8'd5,  16'h0200, 1'b0, 8'd0},  // R8 younger load flushed
    {OP_LK, 8'h05, 8'd40, 16'h0100, 1'b0, 8'd0},  // R8 counter cleared
    {OP_LK, 8'h09, 8'd41, 16'h0400, 1'b1, 8'd0},  // R2
    {OP_LK, 8'h09, 8'd42, 16'h0400, 1'b1, 8'd0},  // R2
    {OP_ST, 8'h00, 8'd1,  16'h0400, 1'b1, 8'd41}, // R7 oldest of two
    {OP_LK, 8'h09, 8'd50, 16'h0000, 1'b0, 8'd0},  // R8
    {OP_CM, 8'h09, 8'd50, 16'h0000, 1'b0, 8'd0},  // R3
    {OP_LK, 8'h0C, 8'd61, 16'h0800, 1'b1, 8'd0},  // R2
    {OP_LK, 8'h0C, 8'd60, 16'h0800, 1'b1, 8'd0},  // R2
    {OP_ST, 8'h00, 8'd55, 16'h0800, 1'b1, 8'd60}, // R7 oldest sits in higher slot
    {OP_ST, 8'h00, 8'd55, 16'h0800, 1'b0, 8'd0}   // R8 both flushed
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller is at a negedge
  task automatic do_lookup(input logic [7:0] pc, input logic [7:0] age,
                           input logic [15:0] addr, output bit spec, output bit rdy);
    lk_valid = 1'b1; lk_pc = {24'd0, pc}; lk_age = age; lk_addr = {16'd0, addr};
    #1;
    spec = lk_spec; rdy = lk_ready;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic do_complete(input logic [7:0] pc, input logic [7:0] age);
    cm_valid = 1'b1; cm_pc = {24'd0, pc}; cm_age = age;
    @(negedge clk);
    cm_valid = 1'b0;
  endtask

  task automatic do_store(input logic [7:0] age, input logic [15:0] addr,
                          output bit v, output logic [7:0] va);
    st_valid = 1'b1; st_age = age; st_addr = {16'd0, addr};
    @(negedge clk);
    v = viol; va = viol_age;
    st_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit s, r, v;
    logic [7:0] va;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    lk_pc = 32'h5;
    #1;
    check(lk_ready == 1'b1, "R1 ready", lk_ready, 1);
    check(viol == 1'b0, "R1 viol", viol, 0);
    check(lk_spec == 1'b0, "R1 spec", lk_spec, 0);
    @(negedge clk);

    // R2 boundary: 14 completions not enough, 15 is
    for (int k = 0; k < 14; k++) do_complete(8'h05, 8'd200);
    do_lookup(8'h05, 8'd3, 16'h0f00, s, r);
    check(s == 1'b0, "R2 at 14", s, 0);
    do_complete(8'h05, 8'd200);
    for (int k = 0; k < 15; k++) begin
      do_complete(8'h09, 8'd200);
      do_complete(8'h0C, 8'd200);
    end

    // table walk
    for (int n = 0; n < NV; n++) begin
      logic [42:0] e;
      e = VEC[n];
      case (e[42:41])
        OP_LK: begin
          do_lookup(e[40:33], e[32:25], e[24:9], s, r);
          check(s == e[8], $sformatf("R2 vec%0d spec", n), s, e[8]);
        end
        OP_CM: do_complete(e[40:33], e[32:25]);
        default: begin
          do_store(e[32:25], e[24:9], v, va);
          check(v == e[8], $sformatf("R7 vec%0d viol", n), v, e[8]);
          if (e[8]) check(va == e[7:0], $sformatf("R7 vec%0d age", n), va, e[7:0]);
        end
      endcase
    end
    // R3: one completion after clear is not enough to speculate
    do_lookup(8'h09, 8'd51, 16'h0000, s, r);
    check(s == 1'b0, "R3 after one inc", s, 0);

    // R3 saturation: 20 completions leave the counter at max
    for (int k = 0; k < 20; k++) do_complete(8'h0D, 8'd200);
    for (int k = 0; k < 8; k++) begin
      do_lookup(8'h0D, 8'(70 + k), 16'(16'h1000 + k * 8), s, r);
      check(s == 1'b1, "R3 saturated spec", s, 1);
      check(r == 1'b1, "R10 ready before full", r, 1);
    end
    // R10 full: offered lookup held off
    lk_valid = 1'b1; lk_pc = 32'h0D; lk_age = 8'd78; lk_addr = 32'h2000;
    #1;
    check(lk_ready == 1'b0, "R10 full", lk_ready, 0);
    @(negedge clk);
    check(lk_ready == 1'b0, "R10 still full", lk_ready, 0);
    lk_valid = 1'b0;
    // R9 release
    do_complete(8'h0D, 8'd70);
    #1;
    check(lk_ready == 1'b1, "R9 slot freed", lk_ready, 1);
    @(negedge clk);
    do_store(8'd0, 16'h1000, v, va);
    check(v == 1'b0, "R9 released not compared", v, 0);
    do_store(8'd0, 16'h2000, v, va);
    check(v == 1'b0, "R10 refused lookup untracked", v, 0);
    do_store(8'd0, 16'h1008, v, va);
    check(v == 1'b1, "R7 viol", v, 1);
    check(va == 8'd71, "R7 age", va, 71);
    do_store(8'd0, 16'h1010, v, va);
    check(v == 1'b0, "R8 flush younger", v, 0);
    do_lookup(8'h0D, 8'd90, 16'h3000, s, r);
    check(s == 1'b0, "R8 clear after viol", s, 0);
    check(r == 1'b1, "R8 tracker emptied", r, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule